// File: doc/BRIEF.md
# DRAM Burst Refresh Sequencer

This block runs a back-to-back burst of refresh cycles over a dynamic RAM array. While a burst-mode enable is held, an external generator clock, which in normal operation would carry the column strobe request, paces the block. The four bank row strobes are driven together as that clock divided by four, and the column strobe is held inactive. A row counter supplies the row address for every strobe and advances at the end of each strobe.

Once the counter has passed the selected last row and that final strobe has ended, the block pulls a bidirectional done pin low. It holds the pin low until the burst enable is removed, so the pin can serve as an end-of-burst interrupt. When the block is idle, pulling the same pin low from outside resets the counter to zero, so that a following burst covers every row. Outside burst mode the row and column strobes simply follow their request inputs. All timing is counted in generator clock periods.

Top module: `burst_refresh_seq`

## Requirements
- R1: When the block is not in burst mode, `ras_n` equals `{4{ras_req_n}}` and `cas_n` equals `cas_req_n`. In burst mode both request inputs have no effect on any output.
- R2: In burst mode all four `ras_n` bits are equal. Counting k = 0 from the clock edge that samples `burst_en` high, `ras_n` is high after edges k mod 4 = 0 and 1 and low after k mod 4 = 2 and 3, until the burst completes.
- R3: `cas_n` is 1 for the whole time the block is in burst mode.
- R4: The row counter starts from the value it held on entry and increments by one (modulo 512) on the edge that ends each low strobe. While a strobe is low, `row_oe` is 1 and `row_addr` shows the counter value.
- R5: On the edge that ends the strobe during which the counter equalled the end-of-count, the burst completes. From then on `flag_oe` is 1 and `ras_n` stays all ones until burst mode is left.
- R6: The end-of-count is 127 for `eoc_sel` = 2'b00, 255 for 2'b01, and 511 for 2'b10 or 2'b11. A burst that starts at count s completes after ((eoc - s) mod 512) + 1 strobes.
- R7: If `flag_in` is 0 at a clock edge while the block is not in burst mode, the counter becomes 0. If `flag_in` is 0 during burst mode, it has no effect.
- R8: `flag_oe` is 1 only in burst mode after completion, and whenever `flag_oe` is 1, `flag_out` is 0.
- R9: On the edge that samples `burst_en` low, the block leaves burst mode. `ras_n` returns to the request value, the divider phase restarts at zero, `flag_oe` falls, and the counter keeps its value. A strobe cut short by the exit does not count.
- R10: While `rst_n` is low at a clock edge, burst mode, the divider phase, the completion flag and the counter are all cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Generator clock; all state changes on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| burst_en | input | 1 | Burst mode request, sampled each edge |
| eoc_sel | input | 2 | End-of-count select |
| ras_req_n | input | 1 | Normal row strobe request, active low |
| cas_req_n | input | 1 | Normal column strobe request, active low |
| flag_in | input | 1 | Level seen on the done pin |
| flag_out | output | 1 | Value driven onto the done pin |
| flag_oe | output | 1 | Drive enable for the done pin |
| ras_n | output | 4 | Bank row strobes, active low |
| cas_n | output | 1 | Column strobe, active low |
| row_addr | output | 9 | Refresh row address |
| row_oe | output | 1 | Row address bus drive enable |

## Verification
The bench counts edges from the one that samples the enable. The strobe level after edge k is due at once, and the counter value on the address bus during strobe k/4 reflects every increment at the edges before it. The done pin is due exactly at edge 4N, where N is the strobe count from R6. The passthrough and exit results are due one edge after the enable falls, and a counter clear one edge after the pin is pulled. The bench changes inputs 1 ns after a rising edge and samples there, so every check reads the values that the preceding edge produced. It computes the expected counter from the start value it tracks, which covers starts of zero, starts inside the range, starts that must wrap, and an exit partway through a burst.

// File: rtl/burst_refresh_seq.sv
module burst_refresh_seq #(
  parameter int CW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          burst_en,
  input  logic [1:0]    eoc_sel,
  input  logic          ras_req_n,
  input  logic          cas_req_n,
  input  logic          flag_in,
  output logic          flag_out,
  output logic          flag_oe,
  output logic [3:0]    ras_n,
  output logic          cas_n,
  output logic [CW-1:0] row_addr,
  output logic          row_oe
);
  localparam logic [CW-1:0] EOC_S = CW'((1 << (CW - 2)) - 1);
  localparam logic [CW-1:0] EOC_M = CW'((1 << (CW - 1)) - 1);
  localparam logic [CW-1:0] EOC_L = CW'((1 << CW) - 1);

  logic          act, done;
  logic [1:0]    phase;
  logic [CW-1:0] cnt;
  logic [CW-1:0] eoc;
  logic          strobe;

  assign eoc = (eoc_sel == 2'b00) ? EOC_S : (eoc_sel == 2'b01) ? EOC_M : EOC_L;
  assign strobe = act & ~done & phase[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act   <= 1'b0;
      done  <= 1'b0;
      phase <= 2'd0;
      cnt   <= '0;
    end else begin
      act <= burst_en;
      if (!act) begin
        phase <= 2'd0;
        done  <= 1'b0;
        if (!flag_in) cnt <= '0;
      end else if (!burst_en) begin
        phase <= 2'd0;
        done  <= 1'b0;
      end else if (!done) begin
        phase <= phase + 2'd1;
        if (phase == 2'd3) begin
          cnt <= cnt + 1'b1;
          if (cnt == eoc) done <= 1'b1;
        end
      end
    end
  end

  assign ras_n    = act ? {4{~strobe}} : {4{ras_req_n}};
  assign cas_n    = act ? 1'b1 : cas_req_n;
  assign row_addr = cnt;
  assign row_oe   = strobe;
  assign flag_oe  = act & done;
  assign flag_out = ~done;
endmodule

module burst_refresh_seq_chk #(
  parameter int CW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          burst_en,
  input logic          act,
  input logic [3:0]    ras_n,
  input logic          cas_n,
  input logic [CW-1:0] row_addr,
  input logic          flag_oe,
  input logic          flag_out
);
  p_banks_equal_r2: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> (ras_n == 4'h0 || ras_n == 4'hF));

  p_cas_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> cas_n);

  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ras_n[0]) && act && $past(act)) |-> row_addr == $past(row_addr) + 1'b1);

  p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_oe && burst_en) |=> flag_oe);

  p_pin_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flag_oe |-> (act && !flag_out));
endmodule

bind burst_refresh_seq burst_refresh_seq_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .burst_en(burst_en), .act(act), .ras_n(ras_n),
  .cas_n(cas_n), .row_addr(row_addr), .flag_oe(flag_oe), .flag_out(flag_out)
);

// File: tb/burst_refresh_seq_test.sv
module burst_refresh_seq_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n, burst_en, ras_req_n, cas_req_n, flag_in;
  logic [1:0] eoc_sel;
  logic       flag_out, flag_oe, cas_n, row_oe;
  logic [3:0] ras_n;
  logic [8:0] row_addr;

  int tests = 0, fails = 0;
  logic [8:0] exp_cnt;

  burst_refresh_seq uut (
    .clk(clk), .rst_n(rst_n), .burst_en(burst_en), .eoc_sel(eoc_sel),
    .ras_req_n(ras_req_n), .cas_req_n(cas_req_n), .flag_in(flag_in),
    .flag_out(flag_out), .flag_oe(flag_oe), .ras_n(ras_n), .cas_n(cas_n),
    .row_addr(row_addr), .row_oe(row_oe)
  );

  task automatic chk(input bit ok, input string req, input int actv, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, actv, expv);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic int eoc_of(input logic [1:0] s);
    return (s == 2'b00) ? 127 : (s == 2'b01) ? 255 : 511;
  endfunction

  task automatic run(input logic [1:0] sel, input int cycles, input bit poke);
    int n, done_k, pulses;
    logic [8:0] d;
    d = 9'(eoc_of(sel)) - exp_cnt;
    n = int'(d) + 1;
    done_k = 4 * n;
    eoc_sel = sel;
    burst_en = 1'b1;
    step();
    for (int k = 0; k < cycles; k++) begin
      bit lo;
      int done_pulses;
      logic [8:0] er;
      lo = (k < done_k) && ((k % 4) >= 2);
      done_pulses = (k / 4 < n) ? k / 4 : n;
      er = exp_cnt + 9'(done_pulses);
      chk(ras_n == (lo ? 4'h0 : 4'hF), "R2 ras_n", ras_n, lo ? 0 : 15);
      chk(cas_n == 1'b1, "R3 cas_n", cas_n, 1);
      if (lo) begin
        chk(row_oe == 1'b1, "R4 row_oe", row_oe, 1);
        chk(row_addr == er, "R4 row_addr", row_addr, er);
      end
      chk(flag_oe == (k >= done_k), "R5 R6 flag_oe", flag_oe, k >= done_k);
      if (flag_oe) chk(flag_out == 1'b0, "R8 flag_out", flag_out, 0);
      ras_req_n = k[0];
      cas_req_n = k[1];
      flag_in = !(poke && (k % 7 == 5));
      step();
    end
    pulses = ((cycles - 1) / 4 < n) ? (cycles - 1) / 4 : n;
    exp_cnt = exp_cnt + 9'(pulses);
    flag_in = 1'b1;
    burst_en = 1'b0;
    ras_req_n = 1'b1;
    cas_req_n = 1'b0;
    step();
    chk(ras_n == 4'hF, "R9 ras_n after exit", ras_n, 15);
    chk(cas_n == 1'b0, "R1 cas_n after exit", cas_n, 0);
    chk(flag_oe == 1'b0, "R9 flag_oe after exit", flag_oe, 0);
    chk(row_oe == 1'b0, "R9 row_oe after exit", row_oe, 0);
    chk(row_addr == exp_cnt, "R9 counter kept", row_addr, exp_cnt);
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; burst_en = 1'b0; eoc_sel = 2'b00;
    ras_req_n = 1'b1; cas_req_n = 1'b1; flag_in = 1'b1;
    step(); step();
    chk(flag_oe == 1'b0, "R10 flag_oe in reset", flag_oe, 0);
    chk(ras_n == 4'hF, "R10 ras_n in reset", ras_n, 15);
    chk(row_addr == 9'd0, "R10 counter in reset", row_addr, 0);
    rst_n = 1'b1;
    exp_cnt = 9'd0;
    step();
    ras_req_n = 1'b0; cas_req_n = 1'b0; #1;
    chk(ras_n == 4'h0, "R1 ras_n passthrough", ras_n, 0);
    chk(cas_n == 1'b0, "R1 cas_n passthrough", cas_n, 0);
    ras_req_n = 1'b1; cas_req_n = 1'b1; #1;
    chk(ras_n == 4'hF, "R1 ras_n passthrough", ras_n, 15);
    chk(cas_n == 1'b1, "R1 cas_n passthrough", cas_n, 1);
    step();

    run(2'b00, 4 * 128 + 8, 1'b0);

    flag_in = 1'b0; step(); flag_in = 1'b1;
    exp_cnt = 9'd0;
    chk(row_addr == 9'd0, "R7 clear while idle", row_addr, 0);

    run(2'b01, 4 * 256 + 6, 1'b1);
    run(2'b10, 4 * 256 + 5, 1'b0);
    run(2'b11, 4 * 512 + 9, 1'b1);
    run(2'b00, 7, 1'b0);
    run(2'b00, 11, 1'b0);
    run(2'b00, 4 * 126 + 4, 1'b1);

    rst_n = 1'b0; step(); rst_n = 1'b1;
    exp_cnt = 9'd0;
    chk(row_addr == 9'd0, "R10 counter after reset", row_addr, 0);
    run(2'b00, 4 * 128 + 3, 1'b0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule